// File: doc/BRIEF.md
# JTAG In-System Configuration Instruction Controller

This block holds the instruction-dependent logic behind a JTAG test access port. It takes the instruction presented by the TAP, latches it on the instruction-update strobe and then decides which data register sits between TDI and TDO. The data registers are a 1-bit bypass stage, a fixed 32-bit device identifier, a 32-bit user identifier that the host can program, a 1-bit programming stage and a 1-bit readback stage. The TAP state machine, the boundary register and the configuration memory are outside the block. The block reaches them only through its strobe inputs and its enable outputs.

Configuration work takes place inside a session. An enable instruction opens the session and a disable instruction closes it. While no session is open, the programming, no-op and readback instructions act as plain bypass. The write path is enabled only while the init flag is high. The read path is enabled only while the done flag is high. The host sees both flags through the values captured in the 1-bit stages. All data registers change on the rising edge of TCK. TDO is re-timed on the falling edge.

Top module: `jtag_isc_ctrl`

## Requirements
- R1: After an asynchronous reset (trst_n low) the latched instruction is the device-ID code, no session is open, the user ID holds its reset parameter, and tdo, cfg_wr_en, cfg_rd_en and isc_active are all 0.
- R2: Under the device-ID instruction, capture loads bits [0]=1, [11:1]=00000011101, [17:12]=001000, [27:18]=part-code parameter and [31:28]=version parameter. The register then shifts toward TDO with its LSB first. With the default parameters the value is 0x0380803B.
- R3: The bypass code, and every code that is not defined, select a 1-bit stage that captures 0. TDI reaches TDO one shift cycle later.
- R4: An instruction update carrying the enable code opens a session and sets isc_active. An update carrying the disable code closes the session and clears isc_active. Each change takes effect on the update edge.
- R5: When no session is open, the programming, no-op and readback codes select the bypass stage, and cfg_wr_en and cfg_rd_en stay 0.
- R6: Inside a session the no-op code passes TDI to TDO through one stage that captures 0.
- R7: The program-usercode instruction captures the current user ID. It then shifts 32 bits in from TDI, LSB first. On the data-update strobe the shifted value replaces the stored user ID.
- R8: The usercode-read instruction captures the most recently programmed user ID and shifts it out, LSB first.
- R9: Inside a session the programming instruction selects a 1-bit stage that captures cfg_init. cfg_wr_en is high only during shift cycles in which cfg_init is high, and cfg_wr_dat follows TDI.
- R10: Inside a session the readback instruction uses a 1-bit stage. At capture and on every shift edge this stage loads cfg_rd_bit when cfg_done is 1, and loads 0 otherwise. cfg_rd_en is high during capture and shift cycles only while cfg_done is high.
- R11: A data-update strobe under any instruction other than program-usercode leaves the stored user ID unchanged.
- R12: TDO changes only on a falling edge of TCK that comes while shift is asserted. It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| ir_code | input | IR_W | Instruction code from the instruction register |
| ir_update | input | 1 | Instruction-update strobe |
| dr_capture | input | 1 | Data-capture strobe |
| dr_shift | input | 1 | Data-shift enable |
| dr_update | input | 1 | Data-update strobe |
| tdi | input | 1 | Serial test data in |
| cfg_init | input | 1 | Configuration memory ready to be programmed |
| cfg_done | input | 1 | Configuration complete, readback valid |
| cfg_rd_bit | input | 1 | Readback bit from configuration memory |
| tdo | output | 1 | Serial test data out, re-timed on the falling edge |
| cfg_wr_en | output | 1 | Configuration write-path enable |
| cfg_wr_dat | output | 1 | Configuration write data |
| cfg_rd_en | output | 1 | Configuration read-path enable |
| isc_active | output | 1 | Configuration session open |

## Verification
Instruction and session changes, captures, shifts and user-ID updates all land on the rising TCK edge that samples their strobe. The first cycle that sees them is the next one. The shifted bit reaches TDO at the falling edge of the same shift cycle, so bit i of a scan is visible in the i-th shift cycle. The write and read enables are combinational from the current instruction, the session and the flags, so they are due within the cycle that drives them. The bench drives inputs just after the rising edge and samples one nanosecond after the falling edge. It compares every cycle against a behavioural model that advances its state only at the rising edge.

// File: rtl/jtag_isc_pkg.sv
package jtag_isc_pkg;

    // Data register currently placed between TDI and TDO
    typedef enum logic [2:0] {
        DR_BYP   = 3'd0,
        DR_ID    = 3'd1,
        DR_UREAD = 3'd2,
        DR_UPROG = 3'd3,
        DR_PROG  = 3'd4,
        DR_READ  = 3'd5
    } dr_sel_e;

    localparam logic [10:0] MFR_CODE = 11'b00000011101;
    localparam logic [5:0]  FAM_CODE = 6'b001000;

    // Fixed identifier: version | part | family | manufacturer | 1
    function automatic logic [31:0] make_idcode(input logic [3:0] ver,
                                                input logic [9:0] part);
        return {ver, part, FAM_CODE, MFR_CODE, 1'b1};
    endfunction

endpackage

// File: rtl/jtag_isc_decode.sv
module jtag_isc_decode
    import jtag_isc_pkg::*;
#(
    parameter int          IR_W     = 8,
    parameter logic [IR_W-1:0] C_IDCODE = 8'h01,
    parameter logic [IR_W-1:0] C_UREAD  = 8'h02,
    parameter logic [IR_W-1:0] C_NOOP   = 8'h12,
    parameter logic [IR_W-1:0] C_PROG   = 8'h11,
    parameter logic [IR_W-1:0] C_UPROG  = 8'h14,
    parameter logic [IR_W-1:0] C_READ   = 8'h15
) (
    input  logic [IR_W-1:0] code,
    input  logic            sess_open,
    output dr_sel_e         sel
);

    always_comb begin
        sel = DR_BYP;
        if (code == C_IDCODE) begin
            sel = DR_ID;
        end else if (code == C_UREAD) begin
            sel = DR_UREAD;
        end else if (code == C_UPROG) begin
            sel = DR_UPROG;
        end else if (code == C_PROG) begin
            sel = sess_open ? DR_PROG : DR_BYP;
        end else if (code == C_READ) begin
            sel = sess_open ? DR_READ : DR_BYP;
        end else if (code == C_NOOP) begin
            sel = DR_BYP;   // one bypass-style stage, session or not
        end
    end

endmodule

// File: rtl/jtag_isc_shreg.sv
module jtag_isc_shreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         shf,
    input  logic [W-1:0] cap_val,
    input  logic         sin,
    output logic [W-1:0] q
);

    logic [W-1:0] sr_d, sr_q;

    generate
        if (W == 1) begin : g_single
            always_comb begin
                sr_d = sr_q;
                if (cap)      sr_d = cap_val;
                else if (shf) sr_d = sin;
            end
        end else begin : g_multi
            always_comb begin
                sr_d = sr_q;
                if (cap)      sr_d = cap_val;
                else if (shf) sr_d = {sin, sr_q[W-1:1]};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q = sr_q;

endmodule

// File: rtl/jtag_isc_ctrl.sv
module jtag_isc_ctrl
    import jtag_isc_pkg::*;
#(
    parameter int              IR_W     = 8,
    parameter logic [9:0]      PART     = 10'b0011100000,
    parameter logic [3:0]      VERSION  = 4'b0000,
    parameter logic [31:0]     USER_RST = 32'h0000_0000,
    parameter logic [IR_W-1:0] C_IDCODE = 8'h01,
    parameter logic [IR_W-1:0] C_UREAD  = 8'h02,
    parameter logic [IR_W-1:0] C_EN     = 8'h10,
    parameter logic [IR_W-1:0] C_PROG   = 8'h11,
    parameter logic [IR_W-1:0] C_NOOP   = 8'h12,
    parameter logic [IR_W-1:0] C_DIS    = 8'h13,
    parameter logic [IR_W-1:0] C_UPROG  = 8'h14,
    parameter logic [IR_W-1:0] C_READ   = 8'h15,
    parameter logic [IR_W-1:0] C_BYPASS = 8'hFF
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic [IR_W-1:0] ir_code,
    input  logic            ir_update,
    input  logic            dr_capture,
    input  logic            dr_shift,
    input  logic            dr_update,
    input  logic            tdi,
    input  logic            cfg_init,
    input  logic            cfg_done,
    input  logic            cfg_rd_bit,
    output logic            tdo,
    output logic            cfg_wr_en,
    output logic            cfg_wr_dat,
    output logic            cfg_rd_en,
    output logic            isc_active
);

    localparam int          ID_W       = 32;
    localparam logic [ID_W-1:0] IDCODE_VAL = make_idcode(VERSION, PART);

    typedef struct packed {
        logic [IR_W-1:0] instr;
        logic            sess;
        logic [ID_W-1:0] user;
    } st_t;

    st_t        st_d, st_q;
    dr_sel_e    sel;
    logic       long_sel;
    logic [ID_W-1:0] long_cap, long_q;
    logic       short_cap, short_sin, rd_src;
    logic [0:0] short_q;
    logic       tdo_d, tdo_q;
    logic [IR_W-1:0] instr_q;
    logic [ID_W-1:0] user_id_q;

    // The bypass code needs no match: every unlisted code falls to bypass
    logic unused_bypass;
    assign unused_bypass = ^C_BYPASS;

    jtag_isc_decode #(
        .IR_W(IR_W), .C_IDCODE(C_IDCODE), .C_UREAD(C_UREAD), .C_NOOP(C_NOOP),
        .C_PROG(C_PROG), .C_UPROG(C_UPROG), .C_READ(C_READ)
    ) u_dec (
        .code     (st_q.instr),
        .sess_open(st_q.sess),
        .sel      (sel)
    );

    always_comb begin
        long_sel  = (sel == DR_ID) || (sel == DR_UREAD) || (sel == DR_UPROG);
        long_cap  = (sel == DR_ID) ? IDCODE_VAL : st_q.user;
        rd_src    = cfg_done & cfg_rd_bit;
        short_sin = (sel == DR_READ) ? rd_src : tdi;
        case (sel)
            DR_PROG: short_cap = cfg_init;
            DR_READ: short_cap = rd_src;
            default: short_cap = 1'b0;
        endcase
    end

    jtag_isc_shreg #(.W(ID_W)) u_long (
        .clk    (tck),
        .rst_n  (trst_n),
        .cap    (dr_capture & long_sel),
        .shf    (dr_shift & long_sel),
        .cap_val(long_cap),
        .sin    (tdi),
        .q      (long_q)
    );

    jtag_isc_shreg #(.W(1)) u_short (
        .clk    (tck),
        .rst_n  (trst_n),
        .cap    (dr_capture & ~long_sel),
        .shf    (dr_shift & ~long_sel),
        .cap_val(short_cap),
        .sin    (short_sin),
        .q      (short_q)
    );

    // Next-state logic for instruction, session and user ID
    always_comb begin
        st_d = st_q;
        if (ir_update) begin
            st_d.instr = ir_code;
            if (ir_code == C_EN)       st_d.sess = 1'b1;
            else if (ir_code == C_DIS) st_d.sess = 1'b0;
        end
        if (dr_update && (sel == DR_UPROG)) begin
            st_d.user = long_q;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '{instr: C_IDCODE, sess: 1'b0, user: USER_RST};
        else         st_q <= st_d;
    end

    // TDO re-timed on the falling edge
    always_comb begin
        tdo_d = tdo_q;
        if (dr_shift) tdo_d = long_sel ? long_q[0] : short_q[0];
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo_q <= 1'b0;
        else         tdo_q <= tdo_d;
    end

    assign tdo        = tdo_q;
    assign cfg_wr_en  = (sel == DR_PROG) & dr_shift & cfg_init;
    assign cfg_wr_dat = tdi;
    assign cfg_rd_en  = (sel == DR_READ) & (dr_capture | dr_shift) & cfg_done;
    assign isc_active = st_q.sess;
    assign instr_q    = st_q.instr;
    assign user_id_q  = st_q.user;

endmodule

// File: rtl/jtag_isc_ctrl_chk.sv
module jtag_isc_ctrl_chk #(
    parameter int              IR_W    = 8,
    parameter logic [IR_W-1:0] C_EN    = 8'h10,
    parameter logic [IR_W-1:0] C_DIS   = 8'h13,
    parameter logic [IR_W-1:0] C_UPROG = 8'h14
) (
    input logic            tck,
    input logic            trst_n,
    input logic [IR_W-1:0] ir_code,
    input logic            ir_update,
    input logic            dr_shift,
    input logic            dr_update,
    input logic            cfg_init,
    input logic            cfg_done,
    input logic            tdo,
    input logic            cfg_wr_en,
    input logic            cfg_rd_en,
    input logic            isc_active,
    input logic [IR_W-1:0] instr_q,
    input logic [31:0]     user_id_q
);

    AST_WR_GATED: assert property (@(posedge tck) disable iff (!trst_n)
        cfg_wr_en |-> (cfg_init && dr_shift && isc_active)); // R9

    AST_RD_GATED: assert property (@(posedge tck) disable iff (!trst_n)
        cfg_rd_en |-> (cfg_done && isc_active)); // R10

    AST_NO_SESSION_EN: assert property (@(posedge tck) disable iff (!trst_n)
        !isc_active |-> (!cfg_wr_en && !cfg_rd_en)); // R5

    AST_SESSION_OPEN: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_update && ir_code == C_EN) |=> isc_active); // R4

    AST_SESSION_CLOSE: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_update && ir_code == C_DIS) |=> !isc_active); // R4

    AST_USER_KEEP: assert property (@(posedge tck) disable iff (!trst_n)
        !(dr_update && instr_q == C_UPROG) |=> $stable(user_id_q)); // R11

    AST_TDO_HOLD: assert property (@(negedge tck) disable iff (!trst_n)
        !dr_shift |=> $stable(tdo)); // R12

endmodule

bind jtag_isc_ctrl jtag_isc_ctrl_chk #(
    .IR_W(IR_W), .C_EN(C_EN), .C_DIS(C_DIS), .C_UPROG(C_UPROG)
) u_chk (
    .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .ir_update(ir_update),
    .dr_shift(dr_shift), .dr_update(dr_update), .cfg_init(cfg_init),
    .cfg_done(cfg_done), .tdo(tdo), .cfg_wr_en(cfg_wr_en),
    .cfg_rd_en(cfg_rd_en), .isc_active(isc_active), .instr_q(instr_q),
    .user_id_q(user_id_q)
);

// File: tb/jtag_isc_ctrl_bench.sv
module jtag_isc_ctrl_bench;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic [7:0] ir_code = 8'h00;
    logic       ir_update = 0, dr_capture = 0, dr_shift = 0, dr_update = 0, tdi = 0;
    logic       cfg_init = 0, cfg_done = 0, cfg_rd_bit = 0;
    logic       tdo, cfg_wr_en, cfg_wr_dat, cfg_rd_en, isc_active;

    always #4 tck = ~tck;   // 125 MHz

    jtag_isc_ctrl u_jtag_isc_ctrl (
        .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .ir_update(ir_update),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .cfg_init(cfg_init), .cfg_done(cfg_done),
        .cfg_rd_bit(cfg_rd_bit), .tdo(tdo), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_dat(cfg_wr_dat), .cfg_rd_en(cfg_rd_en), .isc_active(isc_active)
    );

    // Codes and fixed identifier taken from the requirements
    localparam logic [7:0] K_ID = 8'h01, K_UR = 8'h02, K_EN = 8'h10, K_PR = 8'h11,
                           K_NO = 8'h12, K_DI = 8'h13, K_UP = 8'h14, K_RD = 8'h15,
                           K_BY = 8'hFF;
    localparam logic [31:0] K_IDVAL = 32'h0380803B;

    int checks = 0, fails = 0, cycles = 0, wr_seen = 0;
    string cur_req = "R1";
    logic last_tdo;

    // Behavioural reference state
    logic [7:0]  m_instr = K_ID;
    logic        m_sess = 0, m_short = 0, m_tdo = 0;
    logic [31:0] m_long = 0, m_user = 0;

    // 0 bypass, 1 id, 2 user read, 3 user program, 4 program, 5 readback
    function automatic int sel_of(input logic [7:0] c, input logic s);
        if (c == K_ID) return 1;
        if (c == K_UR) return 2;
        if (c == K_UP) return 3;
        if (c == K_PR && s) return 4;
        if (c == K_RD && s) return 5;
        return 0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic u,
                        input logic iu, input logic [7:0] code, input logic d);
        int sl;
        logic ew, er, rsrc;
        dr_capture = c; dr_shift = s; dr_update = u; ir_update = iu;
        ir_code = code; tdi = d;
        sl = sel_of(m_instr, m_sess);
        @(negedge tck);
        if (s) m_tdo = (sl >= 1 && sl <= 3) ? m_long[0] : m_short;
        #1;
        ew = (sl == 4) && s && cfg_init;
        er = (sl == 5) && (c || s) && cfg_done;
        chk(cur_req, "tdo", {31'd0, tdo}, {31'd0, m_tdo});
        chk(cur_req, "cfg_wr_en", {31'd0, cfg_wr_en}, {31'd0, ew});
        chk(cur_req, "cfg_rd_en", {31'd0, cfg_rd_en}, {31'd0, er});
        chk(cur_req, "isc_active", {31'd0, isc_active}, {31'd0, m_sess});
        if (ew) chk("R9", "cfg_wr_dat", {31'd0, cfg_wr_dat}, {31'd0, d});
        if (cfg_wr_en) wr_seen++;
        last_tdo = tdo;
        @(posedge tck);
        rsrc = cfg_done & cfg_rd_bit;
        if (u && sl == 3) m_user = m_long;
        if (c) begin
            if (sl == 1) m_long = K_IDVAL;
            else if (sl == 2 || sl == 3) m_long = m_user;
            else m_short = (sl == 4) ? cfg_init : (sl == 5) ? rsrc : 1'b0;
        end else if (s) begin
            if (sl >= 1 && sl <= 3) m_long = {d, m_long[31:1]};
            else m_short = (sl == 5) ? rsrc : d;
        end
        if (iu) begin
            m_instr = code;
            if (code == K_EN) m_sess = 1;
            else if (code == K_DI) m_sess = 0;
        end
        #1;
        dr_capture = 0; dr_shift = 0; dr_update = 0; ir_update = 0;
    endtask

    task automatic load_ir(input logic [7:0] code);
        step(0, 0, 0, 1, code, 0);
    endtask

    task automatic scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        step(1, 0, 0, 0, 8'h00, 0);
        for (int i = 0; i < n; i++) begin
            step(0, 1, 0, 0, 8'h00, din[i]);
            dout[i] = last_tdo;
        end
        step(0, 0, 1, 0, 8'h00, 0);
    endtask

    initial begin
        forever begin
            @(posedge tck);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] o;
        repeat (3) @(posedge tck);
        #1;
        cur_req = "R1";
        chk("R1", "tdo at reset", {31'd0, tdo}, 32'd0);
        chk("R1", "isc_active at reset", {31'd0, isc_active}, 32'd0);
        chk("R1", "enables at reset", {30'd0, cfg_wr_en, cfg_rd_en}, 32'd0);
        trst_n = 1;
        @(posedge tck); #1;

        // R1 + R2: default instruction is the device ID
        cur_req = "R2";
        scan(32, 32'h0, o);
        chk("R2", "idcode after reset", o, K_IDVAL);

        // R3: bypass code and an undefined code
        cur_req = "R3";
        load_ir(K_BY);
        scan(8, 32'hB2, o);
        chk("R3", "bypass delay", o, {24'd0, 8'h64});
        load_ir(8'h5A);
        scan(8, 32'h6D, o);
        chk("R3", "undefined code bypass", o, {24'd0, 8'hDA});

        // R5: session-gated codes outside a session
        cur_req = "R5";
        cfg_init = 1; cfg_done = 1; cfg_rd_bit = 1;
        wr_seen = 0;
        load_ir(K_PR);
        scan(4, 32'hF, o);
        chk("R5", "program outside session is bypass", o, 32'hE);
        chk("R5", "no write enable outside session", wr_seen, 0);
        load_ir(K_RD);
        scan(4, 32'h5, o);
        chk("R5", "read outside session is bypass", o, 32'hA);

        // R7 + R8: program the user ID and read it back
        cur_req = "R7";
        load_ir(K_UP);
        scan(32, 32'hA5C31E77, o);
        chk("R7", "old user id out", o, 32'h0);
        cur_req = "R8";
        load_ir(K_UR);
        scan(32, 32'h0, o);
        chk("R8", "usercode readback", o, 32'hA5C31E77);

        // R4: open session
        cur_req = "R4";
        load_ir(K_EN);
        chk("R4", "session open", {31'd0, isc_active}, 32'd1);

        // R6: no-op in session
        cur_req = "R6";
        load_ir(K_NO);
        scan(6, 32'h2B, o);
        chk("R6", "noop one stage", o, 32'h16);

        // R9: programming with init low, then high
        cur_req = "R9";
        load_ir(K_PR);
        cfg_init = 0; wr_seen = 0;
        scan(5, 32'h1F, o);
        chk("R9", "no write with init low", wr_seen, 0);
        chk("R9", "captured init low", {31'd0, o[0]}, 32'd0);
        cfg_init = 1; wr_seen = 0;
        scan(5, 32'h13, o);
        chk("R9", "write enable count", wr_seen, 5);
        chk("R9", "program stage stream", o, 32'h07);

        // R10: readback with done low, then with a pattern
        cur_req = "R10";
        load_ir(K_RD);
        cfg_done = 0; cfg_rd_bit = 1;
        scan(6, 32'h0, o);
        chk("R10", "readback gated by done", o, 32'h0);
        cfg_done = 1;
        begin
            logic [7:0] p;
            p = 8'b1001_1011;
            o = '0;
            cfg_rd_bit = p[0];
            step(1, 0, 0, 0, 8'h00, 0);
            for (int i = 0; i < 7; i++) begin
                cfg_rd_bit = p[i+1];
                step(0, 1, 0, 0, 8'h00, 0);
                o[i] = last_tdo;
            end
            chk("R10", "readback stream", o, {25'd0, p[6:0]});
        end

        // R11: update under other instructions leaves the user ID
        cur_req = "R11";
        load_ir(K_ID);
        scan(32, 32'hFFFFFFFF, o);
        load_ir(K_BY);
        scan(3, 32'h7, o);
        load_ir(K_UR);
        scan(32, 32'h0, o);
        chk("R11", "user id kept", o, 32'hA5C31E77);

        // R12: TDO holds outside shift while TDI toggles
        cur_req = "R12";
        begin
            logic held;
            held = last_tdo;
            for (int i = 0; i < 5; i++) begin
                step(0, 0, 0, 0, 8'h00, i[0]);
                chk("R12", "tdo hold", {31'd0, tdo}, {31'd0, held});
            end
        end

        // R4 + R5: close the session, programming falls back to bypass
        cur_req = "R4";
        load_ir(K_DI);
        chk("R4", "session closed", {31'd0, isc_active}, 32'd0);
        cur_req = "R5";
        load_ir(K_PR);
        wr_seen = 0;
        scan(4, 32'h9, o);
        chk("R5", "no write after disable", wr_seen, 0);
        chk("R5", "bypass after disable", o, 32'h2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule